// File: doc/BRIEF.md
# TDM Frame Sync Generator and Checker

This block keeps frame timing for a time-division multiplexed serial bus whose timing comes from a bit clock. A clock block supplies one-cycle strobes for each rising and each falling bit-clock edge on the system clock. Every strobe is one half bit clock. The block counts these half periods across a frame made of 8-bit slots, with an optional leading frame bit. It reports the current slot and the bit within that slot.

In generate mode it drives a frame sync pulse. The pulse has a programmed width and a programmed lead, both counted in half bit clocks ahead of slot 0, bit 0.

In receive mode it hunts for an incoming sync and aligns its counter to the first sync it sees. After that it judges every frame. A frame is good when it holds exactly one sync start, at the expected half-period position. A sync that is absent, doubled or in the wrong place raises event pulses.

The same geometry settings drive both modes: slot count, frame bit, sync lead, bit length and the two polarities. They must therefore be set correctly even when the block only receives.

Top module: `tdm_fsync`

## Requirements
- R1: With `en` low, and within two clocks of `en` falling, `fs_out` sits at its idle level (equal to `fs_inv`). `slot_cnt`, `bit_cnt`, `in_frame_bit`, `sync_good`, `sync_missing` and `sync_extra` are all 0.
- R2: The frame has `slots`*8 bits, plus 1 when `frame_bit` is 1. The frame bit comes first. Half positions run from 0 to 2*B*bits-1, where B is bit clocks per bit, and then wrap to 0. The bit index at position p is p/(2B). When `frame_bit` is 1, bit index 0 sets `in_frame_bit`=1 and slot and bit read 0. Every other bit index d, counted after the frame bit, gives `slot_cnt`=d/8 and `bit_cnt`=d%8. All outputs update on the clock that samples the strobe.
- R3: `bit_len` gives B: code 0 gives 1 bit clock, code 1 gives 2, and codes 2 and 3 both give 4.
- R4: In generate mode, a bit time starts on the rising strobe when `bclk_inv`=0 and on the falling strobe when `bclk_inv`=1. After enable, the counter waits for the first bit-start strobe, which becomes position 0. Every strobe after that advances the counter by one.
- R5: In generate mode, the sync start position is S = (L - `fs_loc`) mod F. L is 2B when `frame_bit`=1 and 0 otherwise, and F is the frame length in half periods. `fs_out` is asserted at every position p with (p - S) mod F < `fs_len`.
- R6: With `fs_inv`=0 the sync idles low and asserts high. With `fs_inv`=1 it is the reverse, on `fs_out` and in how `fs_in` is read.
- R7: In receive mode, the first strobe at which `fs_in` turns asserted loads the counter with S. The counter runs freely from there on.
- R8: In receive mode, at the strobe of position F-1, `sync_good` becomes 1 if the frame just ended held exactly one sync start (asserted now, not asserted at the previous strobe), at position S. Otherwise it becomes 0.
- R9: In receive mode, `sync_missing` is high for one clock after the frame-end strobe when no sync start fell at position S in that frame.
- R10: In receive mode, `sync_extra` is high for one clock after the frame-end strobe when any sync start fell at a position other than S. A misplaced sync raises both R9 and R10.
- R11: In generate mode, `sync_missing` and `sync_extra` never pulse and `sync_good` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; low holds the block idle |
| gen_mode | input | 1 | 1 generates sync, 0 receives and checks it |
| bclk_rise | input | 1 | One-cycle strobe on a bit-clock rising edge |
| bclk_fall | input | 1 | One-cycle strobe on a bit-clock falling edge |
| bclk_inv | input | 1 | 0: rising edge starts a bit time, 1: falling edge |
| fs_inv | input | 1 | 0: sync active high, 1: sync active low |
| bit_len | input | 2 | Bit clocks per bit code |
| slots | input | 10 | Number of 8-bit slots per frame |
| frame_bit | input | 1 | Adds one leading frame bit |
| fs_loc | input | 5 | Sync lead before slot 0 bit 0, in half bit clocks |
| fs_len | input | 5 | Generated sync width, in half bit clocks |
| fs_in | input | 1 | Received sync pin level |
| fs_out | output | 1 | Generated sync pin level |
| slot_cnt | output | 10 | Current slot |
| bit_cnt | output | 3 | Current bit within the slot |
| in_frame_bit | output | 1 | Current bit is the frame bit |
| sync_good | output | 1 | Last complete frame had one correctly placed sync |
| sync_missing | output | 1 | Pulse: no sync at the expected position |
| sync_extra | output | 1 | Pulse: sync at an unexpected position |

## Verification
A half-period counter at a wrong value shows on the same strobe as a wrong `slot_cnt` or `bit_cnt`. In generate mode it also shows as a shifted `fs_out` edge within one frame. A wrong frame length or sync start in receive mode stays hidden until the next frame-end strobe, where it appears as a false `sync_missing` or `sync_extra` and a dropped `sync_good`. The bench therefore compares every output after every strobe across several full frames, and checks again one clock later that the event pulses have cleared.

// File: rtl/tdm_fsync_pkg.sv
`timescale 1ns/1ps
package tdm_fsync_pkg;
    parameter int SLOT_W = 10;
    parameter int HALF_W = 5;
    // frame bits <= 2^SLOT_W*8, times up to 8 half periods per bit
    localparam int POS_W = SLOT_W + 7;

    typedef logic [POS_W-1:0] pos_t;

    typedef struct packed {
        pos_t       frame_halves;
        pos_t       sync_start;
        logic [1:0] shift;
    } geom_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_RUN  = 2'd2
    } run_st_t;

    // log2 of half periods per bit; code 3 behaves as code 2
    function automatic logic [1:0] half_shift(input logic [1:0] code);
        case (code)
            2'd0:    return 2'd1;
            2'd1:    return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    // (a - b) mod m for a, b below m
    function automatic pos_t mod_sub(input pos_t a, input pos_t b, input pos_t m);
        return (a >= b) ? (a - b) : (a + m - b);
    endfunction
endpackage

// File: rtl/tdm_geom.sv
`timescale 1ns/1ps
module tdm_geom
    import tdm_fsync_pkg::*;
(
    input  logic [1:0]        bit_len,
    input  logic [SLOT_W-1:0] slots,
    input  logic              frame_bit,
    input  logic [HALF_W-1:0] fs_loc,
    output geom_t             geo
);
    pos_t bits;
    pos_t lead;

    always_comb begin
        geo.shift        = half_shift(bit_len);
        bits             = pos_t'({slots, 3'b000}) + pos_t'(frame_bit);
        geo.frame_halves = bits << geo.shift;
        lead             = frame_bit ? (pos_t'(1) << geo.shift) : '0;
        geo.sync_start   = mod_sub(lead, pos_t'(fs_loc), geo.frame_halves);
    end
endmodule

// File: rtl/tdm_frame_cnt.sv
`timescale 1ns/1ps
module tdm_frame_cnt
    import tdm_fsync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              gen,
    input  logic              frame_bit,
    input  logic [HALF_W-1:0] fs_len,
    input  geom_t             geo,
    input  logic              edge_any,
    input  logic              bit_start,
    input  logic              sync_start_det,
    output logic              step,
    output pos_t              next_pos,
    output logic              frame_end,
    output logic [SLOT_W-1:0] slot_idx,
    output logic [2:0]        bit_idx,
    output logic              in_fb,
    output logic              gen_window
);
    run_st_t st;
    pos_t    hpos;
    pos_t    last_pos;
    pos_t    bidx;
    logic [SLOT_W+2:0] didx;
    logic    running;

    always_comb begin
        running  = (st == ST_RUN);
        last_pos = geo.frame_halves - pos_t'(1);
        step     = edge_any && (running ||
                   ((st == ST_HUNT) && (gen ? bit_start : sync_start_det)));
        if (running)
            next_pos = (hpos == last_pos) ? '0 : hpos + pos_t'(1);
        else
            next_pos = gen ? '0 : geo.sync_start;
        frame_end = step && (next_pos == last_pos);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st   <= ST_IDLE;
            hpos <= '0;
        end else if (st == ST_IDLE) begin
            st <= ST_HUNT;
        end else if (step) begin
            st   <= ST_RUN;
            hpos <= next_pos;
        end
    end

    always_comb begin
        bidx = hpos >> geo.shift;
        in_fb = running && frame_bit && (bidx == '0);
        didx = (SLOT_W+3)'(bidx - pos_t'(frame_bit));
        if (running && !in_fb) begin
            slot_idx = didx[SLOT_W+2:3];
            bit_idx  = didx[2:0];
        end else begin
            slot_idx = '0;
            bit_idx  = '0;
        end
        gen_window = running &&
            (mod_sub(hpos, geo.sync_start, geo.frame_halves) < pos_t'(fs_len));
    end

    // R2
    pos_range_chk: assert property (@(posedge clk) disable iff (rst)
        running |-> (hpos < geo.frame_halves));
    // R1
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (st == ST_IDLE && hpos == '0));
    // R4
    pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && running && !edge_any) |=> $stable(hpos));
endmodule

// File: rtl/tdm_sync_chk.sv
`timescale 1ns/1ps
module tdm_sync_chk
    import tdm_fsync_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic gen,
    input  logic fs_lvl,
    input  logic edge_any,
    input  logic step,
    input  logic frame_end,
    input  pos_t next_pos,
    input  pos_t sync_start,
    output logic start_det,
    output logic miss_pulse,
    output logic extra_pulse,
    output logic sync_good
);
    logic prev_lvl;
    logic seen_ok, seen_bad;
    logic ok_n, bad_n;

    always_comb begin
        start_det = fs_lvl && !prev_lvl;
        ok_n  = seen_ok  | (start_det && (next_pos == sync_start));
        bad_n = seen_bad | (start_det && (next_pos != sync_start));
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            prev_lvl    <= 1'b0;
            seen_ok     <= 1'b0;
            seen_bad    <= 1'b0;
            miss_pulse  <= 1'b0;
            extra_pulse <= 1'b0;
            sync_good   <= 1'b0;
        end else begin
            miss_pulse  <= 1'b0;
            extra_pulse <= 1'b0;
            if (edge_any)
                prev_lvl <= fs_lvl;
            if (gen) begin
                sync_good <= 1'b0;
                seen_ok   <= 1'b0;
                seen_bad  <= 1'b0;
            end else if (step) begin
                if (frame_end) begin
                    miss_pulse  <= !ok_n;
                    extra_pulse <= bad_n;
                    sync_good   <= ok_n && !bad_n;
                    seen_ok     <= 1'b0;
                    seen_bad    <= 1'b0;
                end else begin
                    seen_ok  <= ok_n;
                    seen_bad <= bad_n;
                end
            end
        end
    end

    // R9
    miss_single_chk: assert property (@(posedge clk) disable iff (rst)
        miss_pulse |=> !miss_pulse);
    // R10
    extra_single_chk: assert property (@(posedge clk) disable iff (rst)
        extra_pulse |=> !extra_pulse);
    // R11
    gen_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        gen |=> (!miss_pulse && !extra_pulse));
    // R8
    good_update_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sync_good) |-> ($past(frame_end) || $past(en) == 1'b0 || $past(gen)));
endmodule

// File: rtl/tdm_fsync.sv
`timescale 1ns/1ps
module tdm_fsync
    import tdm_fsync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              gen_mode,
    input  logic              bclk_rise,
    input  logic              bclk_fall,
    input  logic              bclk_inv,
    input  logic              fs_inv,
    input  logic [1:0]        bit_len,
    input  logic [SLOT_W-1:0] slots,
    input  logic              frame_bit,
    input  logic [HALF_W-1:0] fs_loc,
    input  logic [HALF_W-1:0] fs_len,
    input  logic              fs_in,
    output logic              fs_out,
    output logic [SLOT_W-1:0] slot_cnt,
    output logic [2:0]        bit_cnt,
    output logic              in_frame_bit,
    output logic              sync_good,
    output logic              sync_missing,
    output logic              sync_extra
);
    geom_t geo;
    logic  edge_any, bit_start, fs_lvl;
    logic  start_det, step, frame_end, gen_window;
    pos_t  next_pos;

    assign edge_any  = bclk_rise | bclk_fall;
    assign bit_start = bclk_inv ? bclk_fall : bclk_rise;
    assign fs_lvl    = fs_in ^ fs_inv;
    assign fs_out    = (gen_mode && gen_window) ^ fs_inv;

    tdm_geom u_geom (
        .bit_len   (bit_len),
        .slots     (slots),
        .frame_bit (frame_bit),
        .fs_loc    (fs_loc),
        .geo       (geo)
    );

    tdm_frame_cnt u_cnt (
        .clk            (clk),
        .rst            (rst),
        .en             (en),
        .gen            (gen_mode),
        .frame_bit      (frame_bit),
        .fs_len         (fs_len),
        .geo            (geo),
        .edge_any       (edge_any),
        .bit_start      (bit_start),
        .sync_start_det (start_det),
        .step           (step),
        .next_pos       (next_pos),
        .frame_end      (frame_end),
        .slot_idx       (slot_cnt),
        .bit_idx        (bit_cnt),
        .in_fb          (in_frame_bit),
        .gen_window     (gen_window)
    );

    tdm_sync_chk u_chk (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .gen         (gen_mode),
        .fs_lvl      (fs_lvl),
        .edge_any    (edge_any),
        .step        (step),
        .frame_end   (frame_end),
        .next_pos    (next_pos),
        .sync_start  (geo.sync_start),
        .start_det   (start_det),
        .miss_pulse  (sync_missing),
        .extra_pulse (sync_extra),
        .sync_good   (sync_good)
    );
endmodule

// File: tb/sim_tdm_fsync.sv
`timescale 1ns/1ps
module sim_tdm_fsync;
    logic clk = 1'b0, rst = 1'b1, en = 1'b0, gen_mode = 1'b0;
    logic bclk_rise = 1'b0, bclk_fall = 1'b0, bclk_inv = 1'b0, fs_inv = 1'b0;
    logic [1:0] bit_len = 2'd0;
    logic [9:0] slots = 10'd1;
    logic frame_bit = 1'b0, fs_in = 1'b0;
    logic [4:0] fs_loc = 5'd0, fs_len = 5'd0;
    logic fs_out, in_frame_bit, sync_good, sync_missing, sync_extra;
    logic [9:0] slot_cnt;
    logic [2:0] bit_cnt;

    tdm_fsync u0 (
        .clk(clk), .rst(rst), .en(en), .gen_mode(gen_mode),
        .bclk_rise(bclk_rise), .bclk_fall(bclk_fall), .bclk_inv(bclk_inv),
        .fs_inv(fs_inv), .bit_len(bit_len), .slots(slots), .frame_bit(frame_bit),
        .fs_loc(fs_loc), .fs_len(fs_len), .fs_in(fs_in), .fs_out(fs_out),
        .slot_cnt(slot_cnt), .bit_cnt(bit_cnt), .in_frame_bit(in_frame_bit),
        .sync_good(sync_good), .sync_missing(sync_missing), .sync_extra(sync_extra)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        bit    fs;
        int    slot;
        int    bitc;
        bit    fb;
        bit    miss;
        bit    extra;
        bit    good;
        string req;
    } exp_t;

    exp_t q[$];
    int vectors = 0, fails = 0;
    bit done = 1'b0;
    bit rise_next = 1'b1;

    // reference model state
    bit m_run, m_prev, m_ok, m_bad, m_good;
    int m_pos;

    function automatic int halves();
        return (bit_len == 2'd0) ? 2 : (bit_len == 2'd1) ? 4 : 8;
    endfunction
    function automatic int flen();
        return (int'(slots) * 8 + int'(frame_bit)) * halves();
    endfunction
    function automatic int sstart();
        int lead = frame_bit ? halves() : 0;
        return ((lead - int'(fs_loc)) % flen() + flen()) % flen();
    endfunction
    function automatic bit in_win(int p);
        int d = ((p - sstart()) % flen() + flen()) % flen();
        return d < int'(fs_len);
    endfunction

    task automatic compare(exp_t e);
        vectors++;
        if (fs_out !== e.fs || int'(slot_cnt) != e.slot || int'(bit_cnt) != e.bitc ||
            in_frame_bit !== e.fb || sync_missing !== e.miss || sync_extra !== e.extra ||
            sync_good !== e.good) begin
            fails++;
            $display("FAIL %s: got fs=%0b slot=%0d bit=%0d fb=%0b miss=%0b extra=%0b good=%0b, expected fs=%0b slot=%0d bit=%0d fb=%0b miss=%0b extra=%0b good=%0b",
                     e.req, fs_out, slot_cnt, bit_cnt, in_frame_bit, sync_missing, sync_extra,
                     sync_good, e.fs, e.slot, e.bitc, e.fb, e.miss, e.extra, e.good);
        end
    endtask

    function automatic exp_t expect_now(bit miss, bit extra, string req);
        exp_t e;
        int b;
        e.fs = (gen_mode && m_run && in_win(m_pos)) ? !fs_inv : fs_inv;
        e.slot = 0; e.bitc = 0; e.fb = 1'b0;
        if (m_run) begin
            b = m_pos / halves();
            if (frame_bit && b == 0) e.fb = 1'b1;
            else begin
                b = b - int'(frame_bit);
                e.slot = b / 8;
                e.bitc = b % 8;
            end
        end
        e.miss = miss; e.extra = extra; e.good = m_good; e.req = req;
        return e;
    endfunction

    task automatic model_clear();
        m_run = 0; m_prev = 0; m_ok = 0; m_bad = 0; m_good = 0; m_pos = 0;
    endtask

    // monitor: compare after every strobe, away from the edge
    always @(posedge clk) begin
        if (bclk_rise || bclk_fall) begin
            #1;
            if (q.size() == 0) begin
                fails++; vectors++;
                $display("FAIL scoreboard: got strobe result, expected queued item");
            end else begin
                compare(q.pop_front());
            end
        end
    end

    // one half bit clock; a is the asserted sync level on fs_in
    task automatic do_edge(bit a, string req);
        bit rise, bstart, sd, miss_e, extra_e;
        int F, S, np;
        @(negedge clk);
        rise = rise_next;
        rise_next = !rise_next;
        bclk_rise = rise;
        bclk_fall = !rise;
        fs_in = a ^ fs_inv;
        F = flen(); S = sstart();
        bstart = bclk_inv ? !rise : rise;
        sd = a && !m_prev;
        miss_e = 0; extra_e = 0;
        if (m_run || (gen_mode ? bstart : sd)) begin
            np = m_run ? ((m_pos + 1) % F) : (gen_mode ? 0 : S);
            m_pos = np;
            m_run = 1;
            if (!gen_mode) begin
                if (sd) begin
                    if (np == S) m_ok = 1; else m_bad = 1;
                end
                if (np == F - 1) begin
                    miss_e = !m_ok;
                    extra_e = m_bad;
                    m_good = m_ok && !m_bad;
                    m_ok = 0; m_bad = 0;
                end
            end
        end
        if (gen_mode) m_good = 0;
        m_prev = a;
        q.push_back(expect_now(miss_e, extra_e, req));
        @(negedge clk);
        bclk_rise = 1'b0;
        bclk_fall = 1'b0;
        @(negedge clk);
        // pulses last exactly one clock (R9, R10)
        vectors++;
        if (sync_missing !== 1'b0 || sync_extra !== 1'b0) begin
            fails++;
            $display("FAIL R9 R10 pulse width: got miss=%0b extra=%0b, expected 0 0",
                     sync_missing, sync_extra);
        end
    endtask

    task automatic go_idle();
        en = 1'b0;
        model_clear();
        @(negedge clk);
        @(negedge clk);
        compare(expect_now(0, 0, "R1 idle"));
    endtask

    task automatic go_run();
        en = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    // kind: 0 normal, 1 no sync, 2 extra sync, 3 misplaced sync
    task automatic rx_frame(int kind, string req);
        for (int p = 0; p < flen(); p++) begin
            int d = ((p - sstart()) % flen() + flen()) % flen();
            bit a;
            case (kind)
                1:       a = 1'b0;
                2:       a = (d < 2) || p == 12 || p == 13;
                3:       a = (p == 9) || (p == 10);
                default: a = (d < 2);
            endcase
            do_edge(a, req);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got run still active, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        compare(expect_now(0, 0, "R1 reset"));

        // generate: 2 slots, 1 bclk/bit, lead 2, width 2; first strobe is not a bit start
        gen_mode = 1'b1; slots = 10'd2; bit_len = 2'd0; frame_bit = 1'b0;
        fs_loc = 5'd2; fs_len = 5'd2; bclk_inv = 1'b0; fs_inv = 1'b0;
        go_run();
        rise_next = 1'b0;
        repeat (40) do_edge(1'b0, "R2 R4 R5 R11");
        go_idle();

        // generate: frame bit, 2 bclk/bit, inverted polarities
        bclk_inv = 1'b1; fs_inv = 1'b1; slots = 10'd1; bit_len = 2'd1;
        frame_bit = 1'b1; fs_loc = 5'd3; fs_len = 5'd5;
        go_run();
        rise_next = 1'b1;
        repeat (45) do_edge(1'b0, "R2 R3 R4 R5 R6");
        go_idle();

        // generate: undefined bit length code acts as 4 bclk/bit
        bclk_inv = 1'b0; fs_inv = 1'b0; slots = 10'd1; bit_len = 2'd3;
        frame_bit = 1'b0; fs_loc = 5'd0; fs_len = 5'd4;
        go_run();
        rise_next = 1'b1;
        repeat (70) do_edge(1'b0, "R3 R5");
        go_idle();

        // receive: 16 half periods per frame, expected sync start at 6
        gen_mode = 1'b0; slots = 10'd1; bit_len = 2'd0; frame_bit = 1'b0;
        fs_loc = 5'd10; fs_len = 5'd0;
        go_run();
        rise_next = 1'b1;
        rx_frame(0, "R7 R8 lock");
        rx_frame(0, "R8 good");
        rx_frame(1, "R9 missing");
        rx_frame(0, "R8 recover");
        rx_frame(2, "R10 extra");
        rx_frame(0, "R8 recover");
        rx_frame(3, "R9 R10 misplaced");
        rx_frame(0, "R8 recover");
        go_idle();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule